// File: doc/BRIEF.md
# System Timebase and Board I/O Register Block

This block is a small peripheral on a 32-bit word bus. It holds a two-bit register for board LEDs and a sampled copy of two push-button inputs. It has two free-running counters that advance once per second and once per hundredth of a second. A cycle counter advances only when a reloadable 32-bit down counter, which software can read and write, reaches zero. A ten-bit control register drives board select lines and display control lines.

The tick rates come from the system clock through an internal divider chain. That chain is set by the parameter `CLK_HZ`, so a simulation can run with a small clock figure. Reads are combinational from the addressed register. A write lands on the clock edge at which `busWe` is sampled high.

Top module: `sysio_tick_regs`

## Requirements
- R1: After a synchronous active-low reset, every register and counter holds zero. `ledOut` and `miscOut` are zero.
- R2: Byte offsets select the registers: 0x000 LEDs, 0x008 buttons, 0x010 seconds counter, 0x014 centisecond counter, 0x018 cycle counter, 0x020 prescale reload, 0x024 prescale counter, 0x04C control. Every other offset, including a misaligned one, reads as zero, and a write to it changes nothing.
- R3: The LED register keeps write-data bits [1:0] and drives `ledOut`. Read bits [31:2] are zero.
- R4: The button register reads back `btnIn` as sampled at the previous clock edge, in bits [1:0]. Writes to it are ignored.
- R5: The control register keeps write-data bits [9:0], except that bit 2 is reserved and always reads zero. Bit i drives `miscOut[i]`. The bits are: 0 display select, 1 serial slave select, 3 display reset, 4 display register select, 5 display read strobe, 6 backlight, 7 converter select, 8 and 9 expansion selects.
- R6: When the prescale counter is nonzero, it decreases by one each clock. When it is zero, it loads the prescale reload value on the next clock.
- R7: The cycle counter increases by one on each clock at which the prescale counter holds zero.
- R8: The centisecond counter advances once every `CLK_HZ/100` clocks. The seconds counter advances once every `CLK_HZ` clocks.
- R9: A bus write to any counter replaces its value. The write takes priority over an increment, decrement or reload in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register |
| btnIn | input | 2 | Push-button levels |
| ledOut | output | 2 | LED drive |
| miscOut | output | 10 | Select and display control lines |

## Verification
The assertions check the following on every clock: the prescale countdown and reload, the cycle counter stepping only while the prescale value is zero, write priority on each counter, the LED and control outputs following their writes, and unmapped offsets reading zero. The bench scenarios measure the exact tick periods of both time counters. They also show that button writes are ignored, that a button read lags the input by one clock, and that the reset values are correct. Finally, they check one timed prescale sequence against hand-derived values.

// File: rtl/sysio_tick_pkg.sv
package sysio_tick_pkg;
  localparam int DATA_W = 32;
  localparam int MISC_W = 10;
  localparam int LED_W  = 2;

  localparam int OFF_LED    = 'h000;
  localparam int OFF_BTN    = 'h008;
  localparam int OFF_SEC    = 'h010;
  localparam int OFF_CENTI  = 'h014;
  localparam int OFF_CYC    = 'h018;
  localparam int OFF_RELOAD = 'h020;
  localparam int OFF_PRE    = 'h024;
  localparam int OFF_MISC   = 'h04C;

  // bit 2 of the control register is reserved
  localparam logic [MISC_W-1:0] MISC_MASK = 10'h3FB;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_BTN, SEL_SEC, SEL_CENTI,
    SEL_CYC, SEL_RELOAD, SEL_PRE, SEL_MISC
  } rdSelT;

  typedef struct packed {
    logic  wrLed;
    logic  wrMisc;
    logic  wrSec;
    logic  wrCenti;
    logic  wrCyc;
    logic  wrReload;
    logic  wrPre;
    logic  tickCenti;
    logic  tickSec;
    rdSelT rdSel;
  } strobeT;

  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] centi;
    logic [DATA_W-1:0] cyc;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] pre;
  } counterT;
endpackage

// File: rtl/sysio_tick_ctrl.sv
module sysio_tick_ctrl
  import sysio_tick_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobeT            strobe
);
  localparam int CENTI_DIV = CLK_HZ / 100;
  localparam int DIV_W     = $clog2(CENTI_DIV + 1);
  localparam int SEC_STEPS = 100;
  localparam int STEP_W    = $clog2(SEC_STEPS);

  logic [DIV_W-1:0]  centiDiv;
  logic [STEP_W-1:0] secDiv;
  logic              centiWrap;
  logic              secWrap;
  rdSelT             sel;

  assign centiWrap = (centiDiv == DIV_W'(CENTI_DIV - 1));
  assign secWrap   = centiWrap && (secDiv == STEP_W'(SEC_STEPS - 1));

  // the seconds tick is cascaded from the centisecond tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      centiDiv <= '0;
      secDiv   <= '0;
    end else begin
      centiDiv <= centiWrap ? '0 : centiDiv + DIV_W'(1);
      if (centiWrap) secDiv <= (secDiv == STEP_W'(SEC_STEPS - 1)) ? '0 : secDiv + STEP_W'(1);
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_LED):    sel = SEL_LED;
      ADDR_W'(OFF_BTN):    sel = SEL_BTN;
      ADDR_W'(OFF_SEC):    sel = SEL_SEC;
      ADDR_W'(OFF_CENTI):  sel = SEL_CENTI;
      ADDR_W'(OFF_CYC):    sel = SEL_CYC;
      ADDR_W'(OFF_RELOAD): sel = SEL_RELOAD;
      ADDR_W'(OFF_PRE):    sel = SEL_PRE;
      ADDR_W'(OFF_MISC):   sel = SEL_MISC;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdSel     = sel;
    strobe.wrLed     = busWe && (sel == SEL_LED);
    strobe.wrMisc    = busWe && (sel == SEL_MISC);
    strobe.wrSec     = busWe && (sel == SEL_SEC);
    strobe.wrCenti   = busWe && (sel == SEL_CENTI);
    strobe.wrCyc     = busWe && (sel == SEL_CYC);
    strobe.wrReload  = busWe && (sel == SEL_RELOAD);
    strobe.wrPre     = busWe && (sel == SEL_PRE);
    strobe.tickCenti = centiWrap;
    strobe.tickSec   = secWrap;
  end
endmodule

// File: rtl/sysio_tick_dp.sv
module sysio_tick_dp
  import sysio_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [LED_W-1:0]  btnIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [LED_W-1:0]  ledOut,
  output logic [MISC_W-1:0] miscOut,
  output counterT           counters
);
  logic [LED_W-1:0]  ledReg;
  logic [LED_W-1:0]  btnReg;
  logic [MISC_W-1:0] miscReg;
  counterT           cnt;
  logic              preZero;

  assign preZero = (cnt.pre == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg  <= '0;
      btnReg  <= '0;
      miscReg <= '0;
      cnt     <= '0;
    end else begin
      btnReg <= btnIn;
      if (strobe.wrLed)  ledReg  <= busWdata[LED_W-1:0];
      if (strobe.wrMisc) miscReg <= busWdata[MISC_W-1:0] & MISC_MASK;

      if (strobe.wrSec)        cnt.sec <= busWdata;
      else if (strobe.tickSec) cnt.sec <= cnt.sec + DATA_W'(1);

      if (strobe.wrCenti)        cnt.centi <= busWdata;
      else if (strobe.tickCenti) cnt.centi <= cnt.centi + DATA_W'(1);

      if (strobe.wrReload) cnt.reload <= busWdata;

      if (strobe.wrPre)  cnt.pre <= busWdata;
      else if (preZero)  cnt.pre <= cnt.reload;
      else               cnt.pre <= cnt.pre - DATA_W'(1);

      if (strobe.wrCyc)  cnt.cyc <= busWdata;
      else if (preZero)  cnt.cyc <= cnt.cyc + DATA_W'(1);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_LED:    busRdata = DATA_W'(ledReg);
      SEL_BTN:    busRdata = DATA_W'(btnReg);
      SEL_SEC:    busRdata = cnt.sec;
      SEL_CENTI:  busRdata = cnt.centi;
      SEL_CYC:    busRdata = cnt.cyc;
      SEL_RELOAD: busRdata = cnt.reload;
      SEL_PRE:    busRdata = cnt.pre;
      SEL_MISC:   busRdata = DATA_W'(miscReg);
      default:    busRdata = '0;
    endcase
  end

  assign ledOut   = ledReg;
  assign miscOut  = miscReg;
  assign counters = cnt;
endmodule

// File: rtl/sysio_tick_regs.sv
module sysio_tick_regs
  import sysio_tick_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [1:0]        btnIn,
  output logic [1:0]        ledOut,
  output logic [9:0]        miscOut
);
  strobeT  strobe;
  counterT counters;

  sysio_tick_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  sysio_tick_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .btnIn(btnIn),
    .busRdata(busRdata), .ledOut(ledOut), .miscOut(miscOut), .counters(counters)
  );
endmodule

// File: rtl/sysio_tick_chk.sv
module sysio_tick_chk
  import sysio_tick_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [1:0]        ledOut,
  input logic [9:0]        miscOut,
  input counterT           counters
);
  logic wrPre, wrCyc, wrCenti, wrSec, mapped;
  assign wrPre   = busWe && busAddr == ADDR_W'(OFF_PRE);
  assign wrCyc   = busWe && busAddr == ADDR_W'(OFF_CYC);
  assign wrCenti = busWe && busAddr == ADDR_W'(OFF_CENTI);
  assign wrSec   = busWe && busAddr == ADDR_W'(OFF_SEC);
  assign mapped  = busAddr inside {ADDR_W'(OFF_LED), ADDR_W'(OFF_BTN), ADDR_W'(OFF_SEC),
                                   ADDR_W'(OFF_CENTI), ADDR_W'(OFF_CYC), ADDR_W'(OFF_RELOAD),
                                   ADDR_W'(OFF_PRE), ADDR_W'(OFF_MISC)};

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == 32'd0);
  assert_led_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_LED)) |=> ledOut == $past(busWdata[1:0]));
  assert_misc_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_MISC)) |=> miscOut == ($past(busWdata[9:0]) & 10'h3FB));
  assert_pre_countdown_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPre && counters.pre != 32'd0) |=> counters.pre == $past(counters.pre) - 32'd1);
  assert_pre_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPre && counters.pre == 32'd0) |=> counters.pre == $past(counters.reload));
  assert_cyc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCyc && counters.pre == 32'd0) |=> counters.cyc == $past(counters.cyc) + 32'd1);
  assert_cyc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCyc && counters.pre != 32'd0) |=> $stable(counters.cyc));
  assert_pre_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrPre |=> counters.pre == $past(busWdata));
  assert_cyc_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCyc |=> counters.cyc == $past(busWdata));
  assert_centi_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCenti |=> counters.centi == $past(busWdata));
  assert_sec_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrSec |=> counters.sec == $past(busWdata));
endmodule

bind sysio_tick_regs sysio_tick_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .ledOut(ledOut), .miscOut(miscOut), .counters(counters)
);

// File: tb/test_sysio_tick_regs.sv
module test_sysio_tick_regs;
  localparam int CLK_HZ = 1000;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [1:0]        btnIn = 2'b00;
  logic [1:0]        ledOut;
  logic [9:0]        miscOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } itemT;
  itemT expQ[$];

  always #5 clk = ~clk;

  sysio_tick_regs #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) i_sysio_tick_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .btnIn(btnIn), .ledOut(ledOut), .miscOut(miscOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations against the read port
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      itemT it;
      it = expQ.pop_front();
      check(busRdata, it.exp, it.tag);
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(posedge clk); #1;
    busAddr = ADDR_W'(addr); busWdata = data; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rdExp(input int addr, input logic [31:0] exp, input string tag);
    itemT it;
    @(posedge clk); #1;
    busAddr = ADDR_W'(addr);
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  // returns the number of clocks between two successive changes of a counter
  task automatic period(input int addr, output int span);
    logic [31:0] prev;
    int n0 = -1;
    span = -1;
    @(posedge clk); #1;
    busAddr = ADDR_W'(addr);
    @(negedge clk);
    prev = busRdata;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (busRdata !== prev) begin
        prev = busRdata;
        if (n0 < 0) n0 = n;
        else begin
          span = n - n0;
          break;
        end
      end
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int span;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check(32'(ledOut), 0, "R1 ledOut");
    check(32'(miscOut), 0, "R1 miscOut");
    rdExp('h000, 0, "R1 led reg");
    rdExp('h04C, 0, "R1 misc reg");
    rdExp('h010, 0, "R1 seconds");
    rdExp('h014, 0, "R1 centiseconds");
    rdExp('h024, 0, "R1 prescale");
    rdExp('h020, 0, "R1 reload");

    // R3 LED
    wr('h000, 32'hFFFF_FFFD);
    rdExp('h000, 32'h1, "R3 led readback");
    check(32'(ledOut), 32'h1, "R3 ledOut");
    // R2 write to an unmapped offset changes nothing
    wr('h004, 32'h2);
    rdExp('h000, 32'h1, "R2 unmapped write");
    rdExp('h004, 0, "R2 unmapped 0x004");
    rdExp('h01C, 0, "R2 unmapped 0x01C");
    rdExp('h050, 0, "R2 unmapped 0x050");
    rdExp('h026, 0, "R2 misaligned 0x026");

    // R5 control register, bit 2 reserved
    wr('h04C, 32'hFFFF_FFFF);
    rdExp('h04C, 32'h3FB, "R5 misc all ones");
    check(32'(miscOut), 32'h3FB, "R5 miscOut all ones");
    wr('h04C, 32'h0000_0204);
    rdExp('h04C, 32'h200, "R5 misc sparse");
    check(32'(miscOut), 32'h200, "R5 miscOut sparse");

    // R4 buttons
    btnIn = 2'b10;
    rdExp('h008, 32'h2, "R4 button sample");
    wr('h008, 32'h1);
    rdExp('h008, 32'h2, "R4 button write ignored");
    @(posedge clk); #1 btnIn = 2'b01;
    @(negedge clk); busAddr = ADDR_W'('h008);
    #1 check(busRdata, 32'h2, "R4 one clock lag");
    @(negedge clk); check(busRdata, 32'h1, "R4 new level");

    // R6 R7 prescale sequence, reload 3
    wr('h020, 32'd3);
    wr('h024, 32'd3);
    wr('h018, 32'd0);
    rdExp('h024, 32'd0, "R6 prescale reaches zero");
    rdExp('h018, 32'd1, "R7 cycle after first zero");
    rdExp('h024, 32'd2, "R6 prescale after reload");
    rdExp('h018, 32'd1, "R7 cycle holds while nonzero");

    // R9 write priority
    wr('h020, 32'd0);
    wr('h024, 32'd0);
    wr('h018, 32'd500);
    rdExp('h018, 32'd501, "R9 cycle write wins then steps");
    wr('h024, 32'd5);
    rdExp('h024, 32'd4, "R9 prescale write wins over reload");

    // R8 tick periods
    period('h014, span);
    check(32'(span), CLK_HZ / 100, "R8 centisecond period");
    wr('h014, 32'hABCD);
    rdExp('h014, 32'hABCD, "R9 centisecond write");
    period('h010, span);
    check(32'(span), CLK_HZ, "R8 seconds period");
    wr('h010, 32'h1234_5678);
    rdExp('h010, 32'h1234_5678, "R9 seconds write");

    @(posedge clk);
    finishRun();
  end
endmodule